// File: doc/BRIEF.md
# Nibble CPU branch and stack unit

This block owns the 12-bit program counter of a 4-bit processor and a three-deep return-address stack. For each instruction the decoder hands it a branch opcode, the first word's low nibble, the second word's byte, the accumulator-zero and carry flags, an external test pin, the value of an index register and the value of a register pair. From these it forms the address of the next instruction word to fetch. It also returns an immediate nibble for the accumulator when a subroutine returns, and the incremented index value when a loop-count instruction runs.

Fetch, memory buses and the arithmetic unit are outside this block. It only sees flags and register values, and its results for the accumulator and index register are combinational outputs that the register file applies when the instruction retires.

Top module: `nib_branch_unit`

## Requirements
- R1: When `rst_n` is low, `pc` is set to 0 and every stack entry is set to 0. A return issued right after reset therefore loads address 0.
- R2: While `step` is 0, `pc` and the stack keep their values. While `step` is 0, `acc_load` and `idx_wr` are 0.
- R3: On a clock edge with `step`=1, op 0 (one-word, no branch) sets `pc` to `pc`+1 and op 1 (two-word, no branch) sets `pc` to `pc`+2. Both wrap modulo 4096.
- R4: Op 2 (jump) sets `pc` to {`opa`, `imm`}, with `opa` as the upper 4 bits.
- R5: Op 3 (call) pushes `pc`+2 (mod 4096) onto the stack and sets `pc` to {`opa`, `imm`}. Op 4 (return) sets `pc` to the most recently pushed entry and pops it.
- R6: During `step` with op 4, `acc_load` is 1 and `acc_data` equals `opa`. For every other op `acc_load` is 0.
- R7: Op 5 (conditional jump) evaluates `opa` as follows. Bit 2 selects accumulator zero, bit 1 selects carry=1 and bit 0 selects `test_in`=0. The selected tests are ORed, and bit 3 inverts the result. When the result is 1 the jump is taken; otherwise `pc` becomes `pc`+2.
- R8: A taken op 5 jump sets `pc` to {(`pc`+1)[11:8], `imm`}, which is the page of the second instruction word.
- R9: During `step` with op 6 (increment and skip), `idx_wr` is 1 and `idx_data` equals `idx_val`+1 mod 16. If that sum is nonzero, `pc` becomes {(`pc`+1)[11:8], `imm`}; otherwise `pc` becomes `pc`+2.
- R10: Op 7 (indirect jump) sets `pc` to {(`pc`+1)[11:8], `pair_val`}.
- R11: The stack holds 3 entries and wraps. A fourth push overwrites the oldest entry without any indication. Four returns after pushes of A, B, C, D yield D, C, B and then D again.

Op encoding is `op`[2:0]. For op 7 the page comes from `pc`+1 because the counter has already advanced when the instruction is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction retires this cycle |
| op | input | 3 | Branch opcode (0..7, see requirements) |
| opa | input | 4 | Low nibble of the first instruction word |
| imm | input | 8 | Second instruction word |
| acc_zero | input | 1 | Accumulator equals zero |
| carry | input | 1 | Carry flag |
| test_in | input | 1 | External test pin |
| pair_val | input | 8 | Contents of the named register pair |
| idx_val | input | 4 | Contents of the named index register |
| pc | output | 12 | Program counter (next fetch address) |
| acc_load | output | 1 | Accumulator takes `acc_data` |
| acc_data | output | 4 | Immediate nibble for the accumulator |
| idx_wr | output | 1 | Index register takes `idx_data` |
| idx_data | output | 4 | Incremented index value |

## Verification
`acc_load`, `acc_data`, `idx_wr` and `idx_data` are combinational, so they are due in the same cycle as the opcode. The bench samples them one time unit after driving the inputs, well before the rising edge. `pc` and the stack change on the single rising edge that follows `step`, so the new counter is due exactly one cycle after the stimulus. The bench compares it one time unit after that edge against its own model. Stack contents are observed only through the counter value that a later return produces.

// File: rtl/nib_branch_unit.sv
module nib_branch_unit #(
  parameter int NW    = 4,
  parameter int AW    = 12,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [2:0]      op,
  input  logic [NW-1:0]   opa,
  input  logic [2*NW-1:0] imm,
  input  logic            acc_zero,
  input  logic            carry,
  input  logic            test_in,
  input  logic [2*NW-1:0] pair_val,
  input  logic [NW-1:0]   idx_val,
  output logic [AW-1:0]   pc,
  output logic            acc_load,
  output logic [NW-1:0]   acc_data,
  output logic            idx_wr,
  output logic [NW-1:0]   idx_data
);
  localparam int PW   = AW - 2*NW;
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [2:0] OP_SEQ1 = 3'd0, OP_SEQ2 = 3'd1, OP_JUMP = 3'd2,
                         OP_CALL = 3'd3, OP_RET  = 3'd4, OP_COND = 3'd5,
                         OP_ISZ  = 3'd6, OP_IND  = 3'd7;

  logic [AW-1:0]   stk [DEPTH];
  logic [PTRW-1:0] sp, sp_up, sp_dn;
  logic [AW-1:0]   pc_p1, pc_p2, pc_nx;
  logic [PW-1:0]   page;
  logic            cond_hit;

  assign pc_p1 = pc + AW'(1);
  assign pc_p2 = pc + AW'(2);
  assign page  = pc_p1[AW-1 -: PW];
  assign sp_up = (sp == PTRW'(DEPTH-1)) ? '0 : sp + 1'b1;
  assign sp_dn = (sp == '0) ? PTRW'(DEPTH-1) : sp - 1'b1;

  assign cond_hit = opa[3] ^ ((opa[2] & acc_zero) | (opa[1] & carry) | (opa[0] & ~test_in));

  assign idx_data = idx_val + NW'(1);
  assign idx_wr   = step && (op == OP_ISZ);
  assign acc_data = opa;
  assign acc_load = step && (op == OP_RET);

  always_comb begin
    case (op)
      OP_SEQ1: pc_nx = pc_p1;
      OP_SEQ2: pc_nx = pc_p2;
      OP_JUMP,
      OP_CALL: pc_nx = {opa, imm};
      OP_RET:  pc_nx = stk[sp_dn];
      OP_COND: pc_nx = cond_hit ? {page, imm} : pc_p2;
      OP_ISZ:  pc_nx = (idx_data != '0) ? {page, imm} : pc_p2;
      default: pc_nx = {page, pair_val};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (step) begin
      pc <= pc_nx;
      if (op == OP_CALL) begin
        stk[sp] <= pc_p2;
        sp      <= sp_up;
      end else if (op == OP_RET) begin
        sp <= sp_dn;
      end
    end
  end
endmodule

// File: rtl/nib_branch_unit_chk.sv
module nib_branch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [2:0]  op,
  input logic [3:0]  opa,
  input logic [7:0]  imm,
  input logic [3:0]  idx_val,
  input logic [11:0] pc,
  input logic        acc_load,
  input logic [3:0]  acc_data,
  input logic        idx_wr
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !acc_load && !idx_wr);
  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == 3'd0 |=> pc == $past(pc) + 12'd1);
  p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == 3'd2 |=> pc == {$past(opa), $past(imm)});
  p_call_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == 3'd3 |=> pc == {$past(opa), $past(imm)});
  p_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load |-> acc_data == opa && op == 3'd4);
  p_isz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step && op == 3'd6 && idx_val != 4'hF |=> pc[7:0] == $past(imm));
endmodule

bind nib_branch_unit nib_branch_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .op(op), .opa(opa), .imm(imm),
  .idx_val(idx_val), .pc(pc), .acc_load(acc_load), .acc_data(acc_data),
  .idx_wr(idx_wr)
);

// File: tb/nib_branch_unit_bench.sv
module nib_branch_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, step = 0;
  logic [2:0] op = 0;
  logic [3:0] opa = 0, idx_val = 0;
  logic [7:0] imm = 0, pair_val = 0;
  logic acc_zero = 0, carry = 0, test_in = 0;
  logic [11:0] pc;
  logic acc_load, idx_wr;
  logic [3:0] acc_data, idx_data;

  int checks = 0, fails = 0;
  logic [11:0] m_pc;
  logic [11:0] m_stk [3];
  int m_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_branch_unit u_nib_branch_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .opa(opa), .imm(imm),
    .acc_zero(acc_zero), .carry(carry), .test_in(test_in), .pair_val(pair_val),
    .idx_val(idx_val), .pc(pc), .acc_load(acc_load), .acc_data(acc_data),
    .idx_wr(idx_wr), .idx_data(idx_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic cond_ok(input logic [3:0] c, input logic z, input logic cy, input logic t);
    logic any;
    any = (c[2] && z) || (c[1] && cy) || (c[0] && !t);
    return c[3] ? !any : any;
  endfunction

  function automatic logic [11:0] next_pc(input logic [2:0] o, input logic [11:0] p);
    logic [11:0] nxt;
    logic [3:0]  pg;
    pg = 4'((p + 12'd1) >> 8);
    case (o)
      3'd0: nxt = p + 12'd1;
      3'd1: nxt = p + 12'd2;
      3'd2, 3'd3: nxt = {opa, imm};
      3'd4: nxt = m_stk[(m_sp + 2) % 3];
      3'd5: nxt = cond_ok(opa, acc_zero, carry, test_in) ? {pg, imm} : p + 12'd2;
      3'd6: nxt = (4'(idx_val + 4'd1) != 4'd0) ? {pg, imm} : p + 12'd2;
      default: nxt = {pg, pair_val};
    endcase
    return nxt;
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5: return "R7";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input logic [3:0] a, input logic [7:0] b, input string tag);
    logic [11:0] exp_pc;
    step = 1; op = o; opa = a; imm = b;
    #1;
    chk("R6 acc_load", acc_load, o == 3'd4);
    if (o == 3'd4) chk("R6 acc_data", acc_data, a);
    chk("R9 idx_wr", idx_wr, o == 3'd6);
    if (o == 3'd6) chk("R9 idx_data", idx_data, 4'(idx_val + 4'd1));
    exp_pc = next_pc(o, m_pc);
    @(posedge clk); #1;
    if (o == 3'd3) begin m_stk[m_sp] = m_pc + 12'd2; m_sp = (m_sp + 1) % 3; end
    if (o == 3'd4) m_sp = (m_sp + 2) % 3;
    m_pc = exp_pc;
    chk(tag.len() > 0 ? tag : req_of(o), pc, m_pc);
    @(negedge clk);
    step = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4004));
    m_pc = 0; m_sp = 0;
    for (int i = 0; i < 3; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset pc", pc, 12'd0);
    @(negedge clk);
    apply(3'd4, 4'h9, 8'h00, "R1 empty return");
    apply(3'd2, 4'h3, 8'h5A, "R4");
    // R2: idle cycles keep pc
    step = 0; op = 3'd2; opa = 4'hF; imm = 8'hFF;
    #1; chk("R2 idle acc_load", acc_load, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 hold", pc, m_pc);
    // R3 wrap
    apply(3'd2, 4'hF, 8'hFF, "R4");
    apply(3'd0, 4'h0, 8'h00, "R3 wrap");
    apply(3'd2, 4'hF, 8'hFF, "R4");
    apply(3'd1, 4'h0, 8'h00, "R3 wrap2");
    // R8 page from pc+1
    apply(3'd2, 4'h0, 8'hFF, "R4");
    acc_zero = 1; carry = 0; test_in = 1;
    apply(3'd5, 4'b0100, 8'h20, "R8 page cross");
    apply(3'd5, 4'b1100, 8'h40, "R7 inverted not taken");
    carry = 1; acc_zero = 0;
    apply(3'd5, 4'b0010, 8'h60, "R7 carry");
    test_in = 0; carry = 0;
    apply(3'd5, 4'b0001, 8'h70, "R7 test low");
    apply(3'd5, 4'b0000, 8'h80, "R7 none selected");
    // R9 boundary
    idx_val = 4'hF;
    apply(3'd6, 4'h2, 8'h33, "R9 zero falls through");
    idx_val = 4'h3;
    apply(3'd6, 4'h2, 8'h33, "R9 loop");
    pair_val = 8'hC7;
    apply(3'd7, 4'h0, 8'h00, "R10");
    // R11 wrap of stack
    apply(3'd3, 4'h1, 8'h10, "R5 call A");
    apply(3'd3, 4'h2, 8'h20, "R5 call B");
    apply(3'd3, 4'h3, 8'h30, "R5 call C");
    apply(3'd3, 4'h4, 8'h40, "R11 call D");
    for (int k = 0; k < 4; k++) apply(3'd4, 4'(k), 8'h00, "R11 return");
    // random mix
    for (int n = 0; n < 400; n++) begin
      acc_zero = 1'($urandom); carry = 1'($urandom); test_in = 1'($urandom);
      pair_val = 8'($urandom); idx_val = 4'($urandom);
      if ($urandom % 5 == 0) begin
        @(negedge clk);
        chk("R2 random idle", pc, m_pc);
      end
      apply(3'($urandom), 4'($urandom), 8'($urandom), "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule